// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial characters in a fast system clock domain. An external receive clock steps it. That clock is brought into the system clock domain through a short synchronizer, and each of its rising edges becomes a one-cycle tick. The serial line is synchronized through the same depth of flops, so the line value and the tick stay aligned. A packed mode byte selects three things: the number of ticks per bit, the character length, and the parity and stop-bit settings.

In the oversampled modes, a falling line seen at a tick opens a character. The start bit is confirmed from a three-sample vote around its centre, and every following bit is decided by the same vote one bit time later. In the one-tick-per-bit mode, each tick samples exactly one bit. This mode assumes the line is already aligned to the receive clock, and it is not reliable otherwise. The character is delivered on a data port together with a ready flag. Sticky framing, parity and overrun flags accompany it. A read strobe from the host clears ready, and an error-clear strobe clears the flags.

Top module: `osrx_top`

## Requirements
- R1: After a synchronous active-high reset, rx_ready, frame_err, parity_err and overrun are 0 and rx_data is 0.
- R2: mode[1:0] sets the ticks per bit: 2'b10 gives 16, 2'b11 gives 64, and 2'b01 or 2'b00 gives 1. The mode is captured when a start bit is detected.
- R3: mode[3:2] sets the character length: 2'b00 gives 5 bits and each step adds one, up to 8 bits. Bits arrive LSB first, and the unused upper bits of rx_data read 0.
- R4: mode[4] enables a parity bit after the data, and mode[5] selects even (1) or odd (0) parity. A mismatch sets parity_err. The parity bit never appears in rx_data.
- R5: With 16 or 64 ticks per bit, a low line at a tick starts a character. Each bit is then decided from the samples taken 1, 0 and -1 ticks around the centre of its bit cell. In the 1-tick mode the start tick counts as the start bit, and each following tick samples one bit.
- R6: In the oversampled modes, a single inverted sample among the three voted samples does not change the decided bit.
- R7: In the oversampled modes, a start bit that votes high is discarded. The receiver returns to idle and no character is produced.
- R8: A low value at the first stop-bit decision sets frame_err. The character is still delivered with rx_ready.
- R9: If a character completes while rx_ready is 1 and no read happens in that cycle, overrun is set and rx_data is replaced by the new character.
- R10: rd_strobe clears rx_ready. If a character completes in the same cycle, rx_ready stays 1 and overrun is not set.
- R11: err_clr clears all three error flags. If a character completes in the same cycle, that character's errors are still set.
- R12: After the first stop-bit decision, the line is ignored for a number of ticks set by mode[7:6]. 2'b11 gives one bit time and 2'b10 gives half a bit time, with a minimum of 1 tick. Any other code gives 0 ticks. Mode 8'h4D therefore means 1x, 8 bits, no parity and one stop bit.
- R13: Each rising edge of rx_clk gives exactly one tick after two synchronizer stages. The system clock must be at least 4.5 times rx_clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk | input | 1 | External receive clock |
| rx_line | input | 1 | Serial data line, idle high |
| mode | input | 8 | Packed mode byte |
| rd_strobe | input | 1 | Host read pulse, clears ready |
| err_clr | input | 1 | Pulse that clears the error flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting |
| frame_err | output | 1 | Sticky framing error |
| parity_err | output | 1 | Sticky parity error |
| overrun | output | 1 | Sticky overrun |

## Verification
Character completion can fall in the same system cycle as a host read, and also in the same cycle as an error-clear pulse. The bench first times the ready rise of a calibration frame. Because the receive clock is generated in lockstep with the system clock, it can then send identical frames and fire rd_strobe or err_clr exactly at the completion edge. In the read case, ready must stay set with no overrun. In the clear case, the parity and overrun errors of the new character must survive the clear.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;
    localparam int CNT_W    = 7;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] ticks;
        logic [CNT_W-1:0] hold;
        logic [IDX_W:0]   nbits;
        logic             par_en;
        logic             par_even;
    } rx_cfg_t;

    function automatic rx_cfg_t decode_mode(input logic [7:0] m);
        rx_cfg_t c;
        c = '0;
        unique case (m[1:0])
            2'b10:   c.ticks = CNT_W'(16);
            2'b11:   c.ticks = CNT_W'(64);
            default: c.ticks = CNT_W'(1);
        endcase
        unique case (m[7:6])
            2'b10:   c.hold = (c.ticks == CNT_W'(1)) ? CNT_W'(1) : (c.ticks >> 1);
            2'b11:   c.hold = c.ticks;
            default: c.hold = '0;
        endcase
        c.nbits    = (IDX_W+1)'(MIN_BITS) + {{(IDX_W-1){1'b0}}, m[3:2]};
        c.par_en   = m[4];
        c.par_even = m[5];
        return c;
    endfunction

endpackage

// File: rtl/osrx_sync_edge.sv
module osrx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rclk_in,
    input  logic line_in,
    output logic tick,
    output logic line_s
);
    logic [STAGES:0]   rclk_sh;
    logic [STAGES-1:0] line_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rclk_sh <= '0;
            line_sh <= '1;
        end else begin
            rclk_sh <= {rclk_sh[STAGES-1:0], rclk_in};
            line_sh <= {line_sh[STAGES-2:0], line_in};
        end
    end

    assign tick   = rclk_sh[STAGES-1] & ~rclk_sh[STAGES];
    assign line_s = line_sh[STAGES-1];
endmodule

// File: rtl/osrx_voter.sv
module osrx_voter
    import osrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             active,
    input  logic [CNT_W-1:0] ph,
    input  logic [CNT_W-1:0] ticks,
    input  logic             line,
    output logic             decide,
    output logic             bit_val
);
    logic [1:0]       acc;
    logic             x1;
    logic [CNT_W-1:0] half;

    assign x1      = (ticks == CNT_W'(1));
    assign half    = ticks >> 1;
    assign decide  = tick & active & (x1 | (ph == half + CNT_W'(1)));
    assign bit_val = x1 ? line : ((acc + {1'b0, line}) >= 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (tick && active) begin
            if (ph == half - CNT_W'(1))
                acc <= {1'b0, line};
            else if (ph == half)
                acc <= acc + {1'b0, line};
        end
    end
endmodule

// File: rtl/osrx_frame_fsm.sv
module osrx_frame_fsm
    import osrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                line,
    input  logic [7:0]          mode,
    input  logic                rd_strobe,
    input  logic                err_clr,
    input  logic                decide,
    input  logic                bit_val,
    output logic [CNT_W-1:0]    ph,
    output logic [CNT_W-1:0]    ticks,
    output logic                active,
    output logic                done,
    output logic [MAX_BITS-1:0] data_out,
    output logic                ready,
    output logic                fe,
    output logic                pe,
    output logic                ov
);
    rx_state_e          state;
    rx_cfg_t            cfg_q;
    rx_cfg_t            new_cfg;
    logic [IDX_W-1:0]   bidx;
    logic [MAX_BITS-1:0] shreg;
    logic               pbad;
    logic [CNT_W-1:0]   hold_cnt;

    assign new_cfg = decode_mode(mode);
    assign ticks   = cfg_q.ticks;
    assign active  = (state != RX_IDLE);
    assign done    = decide && (state == RX_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cfg_q    <= '0;
            ph       <= '0;
            bidx     <= '0;
            shreg    <= '0;
            pbad     <= 1'b0;
            hold_cnt <= '0;
        end else if (tick) begin
            if (state != RX_IDLE)
                ph <= (ph == cfg_q.ticks - CNT_W'(1)) ? '0 : ph + CNT_W'(1);
            unique case (state)
                RX_IDLE: begin
                    if (!line) begin
                        cfg_q <= new_cfg;
                        bidx  <= '0;
                        shreg <= '0;
                        pbad  <= 1'b0;
                        if (new_cfg.ticks == CNT_W'(1)) begin
                            ph    <= '0;
                            state <= RX_DATA;
                        end else begin
                            ph    <= CNT_W'(1);
                            state <= RX_START;
                        end
                    end
                end
                RX_START: begin
                    if (decide)
                        state <= bit_val ? RX_IDLE : RX_DATA;
                end
                RX_DATA: begin
                    if (decide) begin
                        shreg[bidx] <= bit_val;
                        bidx        <= bidx + IDX_W'(1);
                        if ({1'b0, bidx} == cfg_q.nbits - (IDX_W+1)'(1))
                            state <= cfg_q.par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (decide) begin
                        pbad  <= (^shreg) ^ bit_val ^ ~cfg_q.par_even;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (decide) begin
                        hold_cnt <= cfg_q.hold;
                        state    <= (cfg_q.hold == '0) ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (hold_cnt <= CNT_W'(1))
                        state <= RX_IDLE;
                    else
                        hold_cnt <= hold_cnt - CNT_W'(1);
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            ready    <= 1'b0;
            fe       <= 1'b0;
            pe       <= 1'b0;
            ov       <= 1'b0;
        end else begin
            if (done) begin
                data_out <= shreg;
                ready    <= 1'b1;
            end else if (rd_strobe) begin
                ready <= 1'b0;
            end
            if (done && !bit_val)            fe <= 1'b1;
            else if (err_clr)                fe <= 1'b0;
            if (done && pbad)                pe <= 1'b1;
            else if (err_clr)                pe <= 1'b0;
            if (done && ready && !rd_strobe) ov <= 1'b1;
            else if (err_clr)                ov <= 1'b0;
        end
    end
endmodule

// File: rtl/osrx_top.sv
module osrx_top
    import osrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_clk,
    input  logic                rx_line,
    input  logic [7:0]          mode,
    input  logic                rd_strobe,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun
);
    logic             tick_w;
    logic             line_w;
    logic             decide_w;
    logic             bit_w;
    logic             active_w;
    logic             done_w;
    logic [CNT_W-1:0] ph_w;
    logic [CNT_W-1:0] ticks_w;

    osrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rclk_in (rx_clk),
        .line_in (rx_line),
        .tick    (tick_w),
        .line_s  (line_w)
    );

    osrx_voter u_vote (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .active  (active_w),
        .ph      (ph_w),
        .ticks   (ticks_w),
        .line    (line_w),
        .decide  (decide_w),
        .bit_val (bit_w)
    );

    osrx_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_w),
        .line      (line_w),
        .mode      (mode),
        .rd_strobe (rd_strobe),
        .err_clr   (err_clr),
        .decide    (decide_w),
        .bit_val   (bit_w),
        .ph        (ph_w),
        .ticks     (ticks_w),
        .active    (active_w),
        .done      (done_w),
        .data_out  (rx_data),
        .ready     (rx_ready),
        .fe        (frame_err),
        .pe        (parity_err),
        .ov        (overrun)
    );
endmodule

// File: rtl/osrx_checker.sv
module osrx_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       done,
    input logic       rd_strobe,
    input logic       err_clr,
    input logic [7:0] rx_data,
    input logic       ready,
    input logic       frame_err,
    input logic       parity_err,
    input logic       overrun
);
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !done) |=> !ready);

    assert_done_sets_ready_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

    assert_overrun_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(ready));

    assert_data_held_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_data));

    assert_clear_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !done) |=> (!frame_err && !parity_err && !overrun));

    assert_single_tick_R13: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

bind osrx_top osrx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_w),
    .done       (done_w),
    .rd_strobe  (rd_strobe),
    .err_clr    (err_clr),
    .rx_data    (rx_data),
    .ready      (rx_ready),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .overrun    (overrun)
);

// File: tb/test_osrx_top.sv
module test_osrx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_clk = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] mode = 8'h4D;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, frame_err, parity_err, overrun;

    int          checks = 0;
    int          fails = 0;
    int unsigned cyc = 0;
    int unsigned rise_cyc = 0;
    logic        rdy_prev = 1'b0;

    always #5 clk = ~clk;

    osrx_top i_osrx_top (
        .clk        (clk),
        .rst        (rst),
        .rx_clk     (rx_clk),
        .rx_line    (rx_line),
        .mode       (mode),
        .rd_strobe  (rd_strobe),
        .err_clr    (err_clr),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .frame_err  (frame_err),
        .parity_err (parity_err),
        .overrun    (overrun)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_ready && !rdy_prev) rise_cyc = cyc;
        rdy_prev = rx_ready;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    // One receive-clock period = 6 system cycles; line changes with the falling edge.
    task automatic drive_period(input logic lvl);
        rx_clk  = 1'b0;
        rx_line = lvl;
        repeat (3) @(negedge clk);
        rx_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int fac(input logic [1:0] f);
        case (f)
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] masked(input logic [7:0] m, input logic [7:0] d);
        int n;
        n = 5 + int'(m[3:2]);
        return d & (8'hFF >> (8 - n));
    endfunction

    task automatic send_frame(input logic [7:0] m, input logic [7:0] d, input bit bad_par,
                              input bit stop_low, input int gbit, input int gper, input bit tail_low);
        int f;
        int n;
        int nb;
        logic [11:0] bits;
        logic [7:0]  dm;
        f    = fac(m[1:0]);
        n    = 5 + int'(m[3:2]);
        dm   = masked(m, d);
        mode = m;
        bits = '0;
        for (int i = 0; i < n; i++) bits[1 + i] = dm[i];
        nb = 1 + n;
        if (m[4]) begin
            bits[nb] = (m[5] ? ^dm : ~^dm) ^ bad_par;
            nb++;
        end
        bits[nb] = ~stop_low;
        nb++;
        for (int i = 0; i < nb; i++)
            for (int p = 0; p < f; p++)
                drive_period(bits[i] ^ ((i == gbit) && (p == gper)));
        if (tail_low) drive_period(1'b0);
        repeat ((f == 1) ? 12 : 2 * f) drive_period(1'b1);
    endtask

    task automatic clear_all();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        err_clr   = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_char(input string req, input logic [7:0] ed, input bit efe,
                              input bit epe, input bit eov, input bit do_read);
        logic [11:0] act;
        logic [11:0] exp;
        act = {rx_ready, frame_err, parity_err, overrun, rx_data};
        exp = {1'b1, efe, epe, eov, ed};
        check(act == exp, req, int'(act), int'(exp));
        if (do_read) clear_all();
    endtask

    task automatic check_quiet(input string req);
        logic [3:0] act;
        act = {rx_ready, frame_err, parity_err, overrun};
        check(act == 4'h0, req, int'(act), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R13 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] m;
        logic [7:0] vals [4];
        int unsigned t0;
        int unsigned dcal;
        vals[0] = 8'hA5; vals[1] = 8'h5A; vals[2] = 8'hFF; vals[3] = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({rx_ready, frame_err, parity_err, overrun, rx_data} == 12'h000, "R1 reset",
              int'({rx_ready, frame_err, parity_err, overrun, rx_data}), 0);
        repeat (4) drive_period(1'b1);

        // R5/R12: mode 8'h4D (1x, 8 bits, no parity), every byte value
        for (int d = 0; d < 256; d++) begin
            send_frame(8'h4D, 8'(d), 0, 0, -1, -1, 0);
            check_char("R5 1x 8N1 sweep", 8'(d), 0, 0, 0, 1);
        end

        // R2/R3/R4: lengths x parity settings at 1x and 16x
        for (int fc = 1; fc <= 2; fc++)
            for (int len = 0; len < 4; len++)
                for (int pm = 0; pm < 3; pm++)
                    for (int v = 0; v < ((fc == 1) ? 4 : 2); v++) begin
                        m = {2'b01, (pm == 2), (pm != 0), 2'(len), 2'(fc)};
                        send_frame(m, vals[v], 0, 0, -1, -1, 0);
                        check_char("R3 R4 length/parity sweep", masked(m, vals[v]), 0, 0, 0, 1);
                    end

        // R2: baud code 00 behaves as 1x
        send_frame(8'h4C, 8'h96, 0, 0, -1, -1, 0);
        check_char("R2 code00 as 1x", 8'h96, 0, 0, 0, 1);

        // R2/R13: 64 ticks per bit, rx clock at 1/6 of the system clock
        send_frame(8'h7F, 8'hC3, 0, 0, -1, -1, 0);
        check_char("R2 64x even parity", 8'hC3, 0, 0, 0, 1);
        send_frame(8'h53, 8'h1B, 0, 0, -1, -1, 0);
        check_char("R3 64x 5-bit odd", 8'h1B, 0, 0, 0, 1);

        // R4 parity mismatch
        send_frame(8'h7A, 8'h55, 1, 0, -1, -1, 0);
        check_char("R4 16x 7E parity error", 8'h55, 0, 1, 0, 1);
        send_frame(8'h51, 8'h0A, 1, 0, -1, -1, 0);
        check_char("R4 1x 5O parity error", 8'h0A, 0, 1, 0, 1);

        // R8 framing
        send_frame(8'h4D, 8'h3C, 0, 1, -1, -1, 0);
        check_char("R8 1x stop low", 8'h3C, 1, 0, 0, 1);
        send_frame(8'h4E, 8'hE1, 0, 1, -1, -1, 0);
        check_char("R8 16x stop low", 8'hE1, 1, 0, 0, 1);

        // R6 majority: invert the centre sample of one data bit
        send_frame(8'h4E, 8'hF0, 0, 0, 3, 8, 0);
        check_char("R6 16x centre sample flipped", 8'hF0, 0, 0, 0, 1);
        send_frame(8'h4F, 8'h0F, 0, 0, 6, 31, 0);
        check_char("R6 64x vote sample flipped", 8'h0F, 0, 0, 0, 1);

        // R7 short low pulse at 16x is not a start bit
        mode = 8'h4E;
        repeat (3) drive_period(1'b0);
        repeat (40) drive_period(1'b1);
        check_quiet("R7 start glitch dropped");
        send_frame(8'h4E, 8'h81, 0, 0, -1, -1, 0);
        check_char("R7 frame after glitch", 8'h81, 0, 0, 0, 1);

        // R12 hold after stop: low tick right after stop
        send_frame(8'hCD, 8'h24, 0, 0, -1, -1, 1);
        check_char("R12 two stop bits ignore line", 8'h24, 0, 0, 0, 1);
        send_frame(8'h8D, 8'h42, 0, 0, -1, -1, 1);
        check_char("R12 1.5 stop bits ignore line", 8'h42, 0, 0, 0, 1);
        // R9/R12: one stop bit, the low tick starts a second character (all ones)
        send_frame(8'h4D, 8'h24, 0, 0, -1, -1, 1);
        check_char("R9 overrun with new char", 8'hFF, 0, 0, 1, 1);

        // R10/R11 coincidence, mode 8'h7D (1x, 8 bits, even parity)
        t0 = cyc;
        send_frame(8'h7D, 8'h11, 0, 0, -1, -1, 0);
        dcal = rise_cyc - t0;
        check_char("R10 calibration frame", 8'h11, 0, 0, 0, 0);

        t0 = cyc;
        fork
            send_frame(8'h7D, 8'h22, 0, 0, -1, -1, 0);
            begin
                while (cyc != t0 + dcal - 1) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        check_char("R10 read at completion", 8'h22, 0, 0, 0, 0);

        t0 = cyc;
        fork
            send_frame(8'h7D, 8'h33, 1, 0, -1, -1, 0);
            begin
                while (cyc != t0 + dcal - 1) @(negedge clk);
                err_clr = 1'b1;
                @(negedge clk);
                err_clr = 1'b0;
            end
        join
        check_char("R11 clear at completion", 8'h33, 0, 1, 1, 1);
        check_quiet("R11 R10 flags and ready cleared");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule